// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time and Decay Selection

This block drives the four gate commands of one H-bridge: a high-side and a low-side switch on each of two legs. A current-phase controller supplies the drive direction and a phase enable. A chip-wide enable can shut the bridge off. A constant-off-time current regulator raises a chop request while the winding current has to fall, and a mode input picks how that current recirculates.

During on time the bridge drives one diagonal, chosen by the direction input. During a chop, fast decay turns the bridge off and then re-closes only the low-side switch that sits across the conducting freewheel diode. This is quasi-synchronous rectification: the opposite high side stays open, so the current cannot reverse. Slow decay opens only the conducting low side and, after the dead time, closes the other high side, so the current circulates through the upper half of the bridge.

Each leg has its own dead-time unit. Whenever the state a leg is asked for changes, the leg first goes fully open. It then holds open for `DEAD_CYC` clock cycles, and only after that does the newly requested switch close. The two switches of a leg are therefore never closed together.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are low.
- R2: In no cycle are `gate_hi[i]` and `gate_lo[i]` both high for the same leg i (index 0 is leg 1, index 1 is leg 2).
- R3: With both enables high and `chop_off` low, `dir`=1 settles to leg 1 high side plus leg 2 low side (`gate_hi`=2'b01, `gate_lo`=2'b10), and `dir`=0 settles to leg 2 high side plus leg 1 low side (`gate_hi`=2'b10, `gate_lo`=2'b01).
- R4: When the state required of a leg changes, that leg's gates are both low from the next clock edge for exactly `DEAD_CYC` cycles, and the newly required switch then closes. A switch never closes unless its leg has been open for at least `DEAD_CYC` cycles.
- R5: If the required state of a leg changes again before its dead-time window has finished, the window restarts from the second change.
- R6: With `slow_decay`=0 and `chop_off`=1, both high sides are low from the next edge. The leg that had its high side closed during on time closes its low side after the dead time, and the other leg stays open.
- R7: With `slow_decay`=1 and `chop_off`=1, both low sides are low from the next edge. The leg that had its low side closed during on time closes its high side after the dead time, and the other leg keeps its high side closed.
- R8: When `chop_off` falls, the on-time diagonal of R3 returns through the dead-time rule of R4.
- R9: If `chip_en` or `phase_en` is low at a clock edge, all four gates are low after that edge and stay low while it is held low.
- R10: A change of `dir` during on time opens both legs together for `DEAD_CYC` cycles before the new diagonal is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dir | input | 1 | Drive direction: 1 selects leg 1 high / leg 2 low, 0 the opposite |
| phase_en | input | 1 | Phase enable; low opens the bridge |
| chip_en | input | 1 | Chip enable; low opens the bridge |
| chop_off | input | 1 | Off-time request from the current regulator |
| slow_decay | input | 1 | Decay select: 1 slow (synchronous), 0 fast (quasi-synchronous) |
| gate_hi | output | 2 | High-side gate commands, bit i for leg i+1 |
| gate_lo | output | 2 | Low-side gate commands, bit i for leg i+1 |

## Verification
The bench builds the block with `DEAD_CYC`=3 instead of the default 50. With that value a full dead-time window plus the settled state fits into a six-cycle step, so each transition is followed through its open interval into the driven state. It also makes it practical to re-target a leg in the middle of its window, which exercises the restart of R5. A per-leg expectation model, written from the requirements, predicts every cycle of every transition. That covers the decay-mode swaps during a chop, direction reversals and the enable drops.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  localparam int NUM_LEGS = 2;

  typedef enum logic [1:0] {
    LEG_OPEN = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_drive_e;

endpackage

// File: rtl/hbg_target_dec.sv
module hbg_target_dec
  import hbg_pkg::*;
(
  input  logic       dir,
  input  logic       phase_en,
  input  logic       chip_en,
  input  logic       chop_off,
  input  logic       slow_decay,
  output leg_drive_e leg_tgt [NUM_LEGS]
);

  // src_leg: leg whose high side sources current during on time
  // snk_leg: leg whose low side sinks current during on time
  leg_drive_e src_state;
  leg_drive_e snk_state;

  always_comb begin
    if (!(chip_en && phase_en)) begin
      src_state = LEG_OPEN;
      snk_state = LEG_OPEN;
    end else if (!chop_off) begin
      src_state = LEG_HIGH;
      snk_state = LEG_LOW;
    end else if (slow_decay) begin
      // recirculate through upper half, synchronous rectification
      src_state = LEG_HIGH;
      snk_state = LEG_HIGH;
    end else begin
      // quasi-synchronous: only the low side across the conducting diode
      src_state = LEG_LOW;
      snk_state = LEG_OPEN;
    end
  end

  always_comb begin
    if (dir) begin
      leg_tgt[0] = src_state;
      leg_tgt[1] = snk_state;
    end else begin
      leg_tgt[0] = snk_state;
      leg_tgt[1] = src_state;
    end
  end

endmodule

// File: rtl/hbg_leg_dt.sv
module hbg_leg_dt
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  leg_drive_e tgt,
  output logic       gate_hi,
  output logic       gate_lo
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LAST_OPEN = CW'(DEAD_CYC - 1);

  leg_drive_e       state_q, state_d;
  leg_drive_e       tgt_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (tgt != tgt_q) begin
      // any new requirement: open the leg and restart the window
      state_d = LEG_OPEN;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (state_q != tgt) begin
      // leg is open and waiting to close the requested switch
      if (cnt_q == LAST_OPEN) begin
        state_d = tgt;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LEG_OPEN;
      tgt_q   <= LEG_OPEN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign gate_hi = (state_q == LEG_HIGH);
  assign gate_lo = (state_q == LEG_LOW);

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dir,
  input  logic                phase_en,
  input  logic                chip_en,
  input  logic                chop_off,
  input  logic                slow_decay,
  output logic [NUM_LEGS-1:0] gate_hi,
  output logic [NUM_LEGS-1:0] gate_lo
);

  leg_drive_e leg_tgt [NUM_LEGS];

  hbg_target_dec u_dec (
    .dir        (dir),
    .phase_en   (phase_en),
    .chip_en    (chip_en),
    .chop_off   (chop_off),
    .slow_decay (slow_decay),
    .leg_tgt    (leg_tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_leg_dt #(
      .DEAD_CYC (DEAD_CYC)
    ) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt     (leg_tgt[g]),
      .gate_hi (gate_hi[g]),
      .gate_lo (gate_lo[g])
    );
  end

endmodule

// File: rtl/hbridge_gate_seq_chk.sv
module hbridge_gate_seq_chk #(
  parameter int DEAD_CYC = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_en,
  input logic       chip_en,
  input logic       chop_off,
  input logic       slow_decay,
  input logic [1:0] gate_hi,
  input logic [1:0] gate_lo
);

  localparam int CW = $clog2(DEAD_CYC + 2);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

  logic [CW-1:0] open_run [2];

  for (genvar g = 0; g < 2; g++) begin : g_chk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_run[g] <= '0;
      end else if (gate_hi[g] || gate_lo[g]) begin
        open_run[g] <= '0;
      end else if (open_run[g] != SAT) begin
        open_run[g] <= open_run[g] + 1'b1;
      end
    end

    // R2
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[g] && gate_lo[g]));

    // R4
    hi_after_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[g]) |-> (open_run[g] >= SAT));

    // R4
    lo_after_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[g]) |-> (open_run[g] >= SAT));
  end

  // R9
  disable_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_en && phase_en) |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

  // R6
  fast_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_off && !slow_decay) |=> (gate_hi == 2'b00));

  // R7
  slow_no_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_off && slow_decay) |=> (gate_lo == 2'b00));

endmodule

bind hbridge_gate_seq hbridge_gate_seq_chk #(
  .DEAD_CYC (DEAD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_en   (phase_en),
  .chip_en    (chip_en),
  .chop_off   (chop_off),
  .slow_decay (slow_decay),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo)
);

// File: tb/hbridge_gate_seq_bench.sv
module hbridge_gate_seq_bench;

  localparam int DEAD = 3;

  logic       clk;
  logic       rst_n;
  logic       dir, phase_en, chip_en, chop_off, slow_decay;
  logic [1:0] gate_hi, gate_lo;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [1:0] hi;
    logic [1:0] lo;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // bench model state per leg: 0 open, 1 high side, 2 low side
  int want [2];
  int open_left [2];

  hbridge_gate_seq #(.DEAD_CYC(DEAD)) u_hbridge_gate_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir        (dir),
    .phase_en   (phase_en),
    .chip_en    (chip_en),
    .chop_off   (chop_off),
    .slow_decay (slow_decay),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // required leg state from R3, R6, R7, R9
  function automatic int req_state(input logic d, pe, ce, ch, sl, input int leg);
    int src, snk;
    if (!(pe && ce)) begin src = 0; snk = 0; end
    else if (!ch)    begin src = 1; snk = 2; end
    else if (sl)     begin src = 1; snk = 1; end
    else             begin src = 2; snk = 0; end
    if (d) return (leg == 0) ? src : snk;
    else   return (leg == 0) ? snk : src;
  endfunction

  task automatic step(input logic d, pe, ce, ch, sl, input int n, input string tag);
    @(negedge clk);
    #1;
    dir = d; phase_en = pe; chip_en = ce; chop_off = ch; slow_decay = sl;
    for (int l = 0; l < 2; l++) begin
      int nw;
      nw = req_state(d, pe, ce, ch, sl, l);
      if (nw != want[l]) begin
        want[l] = nw;
        open_left[l] = DEAD;
      end
    end
    for (int j = 0; j < n; j++) begin
      exp_t e;
      e.hi = 2'b00; e.lo = 2'b00; e.tag = tag;
      for (int l = 0; l < 2; l++) begin
        if (open_left[l] > 0) open_left[l]--;
        else begin
          e.hi[l] = (want[l] == 1);
          e.lo[l] = (want[l] == 2);
        end
      end
      exp_q.push_back(e);
    end
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (gate_hi !== e.hi || gate_lo !== e.lo) begin
          n_fail++;
          $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b at %0t",
                   e.tag, gate_hi, gate_lo, e.hi, e.lo, $time);
        end
        n_run++;
        if ((gate_hi & gate_lo) !== 2'b00) begin
          n_fail++;
          $display("FAIL R2: hi=%b lo=%b expected no leg with both set", gate_hi, gate_lo);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dir = 1'b1; phase_en = 1'b0; chip_en = 1'b0; chop_off = 1'b0; slow_decay = 1'b0;
    for (int l = 0; l < 2; l++) begin want[l] = 0; open_left[l] = 0; end
    // drive an enabled pattern during reset: outputs must still be low
    #5 phase_en = 1'b1; chip_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (gate_hi !== 2'b00 || gate_lo !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: hi=%b lo=%b expected hi=00 lo=00", gate_hi, gate_lo);
    end
    phase_en = 1'b0; chip_en = 1'b0;
    rst_n = 1'b1;

    step(1, 0, 0, 0, 0, 4, "R9 disabled idle");
    step(1, 1, 1, 0, 0, 6, "R3 R4 dir1 on");
    step(1, 1, 1, 1, 0, 6, "R6 fast chop dir1");
    step(1, 1, 1, 0, 0, 6, "R8 leave fast chop");
    step(1, 1, 1, 1, 1, 6, "R7 slow chop dir1");
    step(1, 1, 1, 0, 0, 6, "R8 leave slow chop");
    step(0, 1, 1, 0, 0, 6, "R10 reverse to dir0");
    step(0, 1, 1, 1, 0, 6, "R6 fast chop dir0");
    step(0, 1, 1, 1, 1, 6, "R7 fast to slow in chop");
    step(0, 1, 1, 0, 1, 2, "R8 short on");
    step(1, 1, 1, 0, 1, 6, "R5 restart mid window");
    step(1, 0, 1, 0, 0, 4, "R9 phase disable");
    step(1, 1, 1, 0, 0, 6, "R3 re-enable");
    step(1, 1, 0, 0, 0, 4, "R9 chip disable");
    step(0, 1, 1, 0, 0, 6, "R3 dir0 on");
    step(0, 1, 1, 1, 1, 6, "R7 slow chop dir0");

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule